// File: doc/BRIEF.md
# CAN Controller Operating Mode Sequencer

This block holds the control word of a CAN controller and moves the controller between its operating modes: operation, reset and halt, plus a separate sleep state. Software writes a 16-bit control word. It then polls the registered reset-status and halt-status outputs to find out when the requested mode has been reached.

A forced reset takes effect on the next clock edge. Every other mode change waits until the bus-idle input has been high for a programmable number of consecutive clocks. This delay stands in for synchronising to an idle bus. The configuration fields of the control word are written only while the controller is in reset.

An automatic halt on bus-off can be enabled. When the controller enters reset from another mode, it emits a one-cycle pulse that clears the FIFO pointers and error counters elsewhere in the controller.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the block has `sleep_status`=1, `rst_status`=1, `halt_status`=0 and `clr_pulse`=0. `ctl_q` reads 16'h0500, which is the sleep bit (bit 10) together with mode field 01.
- R2: The mode field is at bits 9:8 of the control word. The values are 00 operation, 01 reset, 10 halt and 11 forced reset. `ctl_q` returns the field as last accepted. Operation is indicated by both status outputs being 0.
- R3: A write of mode field 11 sets `rst_status` at the same clock edge that takes the write, whatever the level of `bus_idle`.
- R4: A request for operation, reset or halt completes on the IDLE_CYCLES-th consecutive clock edge after the write at which `bus_idle` is high. A low `bus_idle` restarts the count. The status outputs do not change before completion.
- R5: While sleep is active, the mode field of a write is ignored. A write with bit 10 at 0 leaves sleep.
- R6: Writing bit 10 as 1 enters sleep only when the controller is not in operation mode. While asleep, a pending mode request does not complete.
- R7: The configuration fields are accepted only while `rst_status` is 1 and hold their value otherwise. They are: bit 0 (FIFO mailbox mode), bits 2:1 (identifier format), bit 3 (overrun mode) and bits 12:11 (bus-off recovery).
- R8: When bus-off recovery is 01 and `bus_off` is high while the controller is in operation, `halt_status` is 1 after the next edge and the mode field reads 10. With any other recovery value, `bus_off` has no effect.
- R9: `clr_pulse` is high for exactly one cycle: the first cycle in which `rst_status` is 1 after the controller was in operation or halt. It does not pulse at hardware reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write data |
| bus_idle | input | 1 | Bus is idle; gates non-forced mode changes |
| bus_off | input | 1 | Bus-off entry indication from the protocol engine |
| ctl_q | output | 16 | Control word readback |
| rst_status | output | 1 | Controller is in reset mode |
| halt_status | output | 1 | Controller is in halt mode |
| sleep_status | output | 1 | Controller is asleep |
| clr_pulse | output | 1 | One-cycle clear of FIFO pointers and error counters on reset entry |
| cfg_fifo_mode | output | 1 | FIFO mailbox mode selected |
| cfg_id_fmt | output | 2 | Identifier format select |
| cfg_overrun | output | 1 | Overrun (not overwrite) on message loss |
| cfg_boff_mode | output | 2 | Bus-off recovery select |

## Verification
Mode changes are driven in three ways, and each shows whether the block obeys the timing rule for that path. A held-idle bus shows the exact completion edge. An idle bus interrupted by one busy cycle shows whether the count truly restarts. A busy bus with a forced reset shows whether the forced path really bypasses the timer. Configuration and mode writes are tried both inside and outside reset, and while asleep and awake, to confirm that the gating discards them. Bus-off pulses are applied with the automatic-halt recovery selected and with it deselected.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  localparam int CTL_W     = 16;
  localparam int B_FIFO    = 0;
  localparam int B_IDF_LO  = 1;
  localparam int B_IDF_HI  = 2;
  localparam int B_OVR     = 3;
  localparam int B_MODE_LO = 8;
  localparam int B_MODE_HI = 9;
  localparam int B_SLEEP   = 10;
  localparam int B_BOFF_LO = 11;
  localparam int B_BOFF_HI = 12;

  typedef enum logic [1:0] {
    M_OPER  = 2'b00,
    M_RESET = 2'b01,
    M_HALT  = 2'b10
  } mode_e;

  localparam logic [1:0] REQ_FORCE      = 2'b11;
  localparam logic [1:0] BOFF_AUTO_HALT = 2'b01;

  function automatic mode_e req_target(input logic [1:0] r);
    case (r)
      2'b00:   return M_OPER;
      2'b10:   return M_HALT;
      default: return M_RESET;
    endcase
  endfunction
endpackage

// File: rtl/can_mode_ctl_reg.sv
module can_mode_ctl_reg
  import can_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  mode_e            cur_mode,
  input  logic             in_reset,
  input  logic             autohalt,
  output logic [1:0]       req_q,
  output logic             sleep_q,
  output logic             fifo_q,
  output logic [1:0]       idf_q,
  output logic             ovr_q,
  output logic [1:0]       boff_q,
  output logic             force_rst,
  output logic             req_chg
);
  logic mode_take;
  logic cfg_take;
  logic unused_bits;

  assign unused_bits = ^{wr_data[15:13], wr_data[7:4]};

  always_comb begin
    mode_take = wr_en && !sleep_q;
    force_rst = mode_take && (wr_data[B_MODE_HI:B_MODE_LO] == REQ_FORCE);
    cfg_take  = wr_en && in_reset;
    req_chg   = mode_take || autohalt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= M_RESET;
      sleep_q <= 1'b1;
      fifo_q  <= 1'b0;
      idf_q   <= 2'b00;
      ovr_q   <= 1'b0;
      boff_q  <= 2'b00;
    end else begin
      if (force_rst)
        req_q <= REQ_FORCE;
      else if (autohalt)
        req_q <= M_HALT;
      else if (mode_take)
        req_q <= wr_data[B_MODE_HI:B_MODE_LO];

      if (wr_en) begin
        if (!wr_data[B_SLEEP])
          sleep_q <= 1'b0;
        else if (cur_mode != M_OPER)
          sleep_q <= 1'b1;
      end

      if (cfg_take) begin
        fifo_q <= wr_data[B_FIFO];
        idf_q  <= wr_data[B_IDF_HI:B_IDF_LO];
        ovr_q  <= wr_data[B_OVR];
        boff_q <= wr_data[B_BOFF_HI:B_BOFF_LO];
      end
    end
  end

  // R7: configuration frozen outside reset
  assert_cfg_locked_R7: assert property (@(posedge clk) disable iff (rst)
    !in_reset |=> $stable({fifo_q, idf_q, ovr_q, boff_q}));

  // R5: mode field untouched while asleep
  assert_sleep_blocks_mode_R5: assert property (@(posedge clk) disable iff (rst)
    sleep_q |=> $stable(req_q));
endmodule

// File: rtl/can_mode_idle_timer.sv
module can_mode_idle_timer #(
  parameter int IDLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic restart,
  input  logic bus_idle,
  output logic done
);
  localparam int CW = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;

  generate
    if (IDLE_CYCLES <= 1) begin : g_nocnt
      assign done = armed && bus_idle && !restart;
    end else begin : g_cnt
      logic [CW-1:0] cnt_q;
      localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

      assign done = armed && bus_idle && !restart && (cnt_q == LAST);

      always_ff @(posedge clk) begin
        if (rst || restart || !armed || !bus_idle || done)
          cnt_q <= '0;
        else
          cnt_q <= cnt_q + 1'b1;
      end

      // R4: count never passes its terminal value
      assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

      // R4: a busy bus restarts the count
      assert_busy_restarts_R4: assert property (@(posedge clk) disable iff (rst)
        !bus_idle |=> (cnt_q == '0));
    end
  endgenerate
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] req_q,
  input  logic       force_rst,
  input  logic       bus_off,
  input  logic       bus_idle,
  input  logic [1:0] boff_q,
  input  logic       timer_done,
  output mode_e      cur_mode,
  output logic       rst_st,
  output logic       halt_st,
  output logic       clr_st,
  output logic       autohalt,
  output logic       pending
);
  mode_e mode_d;

  always_comb begin
    autohalt = bus_off && (boff_q == BOFF_AUTO_HALT) &&
               (cur_mode == M_OPER) && !force_rst;
    pending  = (req_target(req_q) != cur_mode);
    if (force_rst)
      mode_d = M_RESET;
    else if (autohalt)
      mode_d = M_HALT;
    else if (timer_done)
      mode_d = req_target(req_q);
    else
      mode_d = cur_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mode <= M_RESET;
      rst_st   <= 1'b1;
      halt_st  <= 1'b0;
      clr_st   <= 1'b0;
    end else begin
      cur_mode <= mode_d;
      rst_st   <= (mode_d == M_RESET);
      halt_st  <= (mode_d == M_HALT);
      clr_st   <= (mode_d == M_RESET) && (cur_mode != M_RESET);
    end
  end

  // R3: forced reset lands at the next edge
  assert_force_reset_R3: assert property (@(posedge clk) disable iff (rst)
    force_rst |=> rst_st);

  // R8: automatic halt on bus-off
  assert_auto_halt_R8: assert property (@(posedge clk) disable iff (rst)
    autohalt |=> halt_st);

  // R9: reset entry always clears
  assert_clear_on_entry_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_st) |-> clr_st);

  // R9: clear is a single cycle
  assert_clear_single_R9: assert property (@(posedge clk) disable iff (rst)
    clr_st |=> !clr_st);

  // R2: status bits never both set
  assert_status_excl_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rst_st, halt_st}));

  // R4: no ordinary mode change on a busy bus
  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!bus_idle && !force_rst && !autohalt) |=> $stable(cur_mode));
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int IDLE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        bus_idle,
  input  logic        bus_off,
  output logic [15:0] ctl_q,
  output logic        rst_status,
  output logic        halt_status,
  output logic        sleep_status,
  output logic        clr_pulse,
  output logic        cfg_fifo_mode,
  output logic [1:0]  cfg_id_fmt,
  output logic        cfg_overrun,
  output logic [1:0]  cfg_boff_mode
);
  logic [1:0] req_q;
  logic       sleep_q;
  logic       force_rst;
  logic       req_chg;
  logic       autohalt;
  logic       pending;
  logic       timer_done;
  mode_e      cur_mode;

  can_mode_ctl_reg u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cur_mode  (cur_mode),
    .in_reset  (rst_status),
    .autohalt  (autohalt),
    .req_q     (req_q),
    .sleep_q   (sleep_q),
    .fifo_q    (cfg_fifo_mode),
    .idf_q     (cfg_id_fmt),
    .ovr_q     (cfg_overrun),
    .boff_q    (cfg_boff_mode),
    .force_rst (force_rst),
    .req_chg   (req_chg)
  );

  can_mode_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .armed    (pending && !sleep_q),
    .restart  (req_chg),
    .bus_idle (bus_idle),
    .done     (timer_done)
  );

  can_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_q      (req_q),
    .force_rst  (force_rst),
    .bus_off    (bus_off),
    .bus_idle   (bus_idle),
    .boff_q     (cfg_boff_mode),
    .timer_done (timer_done),
    .cur_mode   (cur_mode),
    .rst_st     (rst_status),
    .halt_st    (halt_status),
    .clr_st     (clr_pulse),
    .autohalt   (autohalt),
    .pending    (pending)
  );

  assign sleep_status = sleep_q;

  always_comb begin
    ctl_q = '0;
    ctl_q[B_FIFO]              = cfg_fifo_mode;
    ctl_q[B_IDF_HI:B_IDF_LO]   = cfg_id_fmt;
    ctl_q[B_OVR]               = cfg_overrun;
    ctl_q[B_MODE_HI:B_MODE_LO] = req_q;
    ctl_q[B_SLEEP]             = sleep_q;
    ctl_q[B_BOFF_HI:B_BOFF_LO] = cfg_boff_mode;
  end

  // R6: never asleep in operation mode
  assert_no_sleep_in_oper_R6: assert property (@(posedge clk) disable iff (rst)
    sleep_status |-> (rst_status || halt_status));

  // R6: asleep means the mode holds
  assert_sleep_freezes_R6: assert property (@(posedge clk) disable iff (rst)
    sleep_status |=> $stable({rst_status, halt_status}));
endmodule

// File: tb/can_mode_seq_tb.sv
module can_mode_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        bus_idle = 1'b1;
  logic        bus_off = 1'b0;
  logic [15:0] ctl_q;
  logic        rst_status, halt_status, sleep_status, clr_pulse;
  logic        cfg_fifo_mode, cfg_overrun;
  logic [1:0]  cfg_id_fmt, cfg_boff_mode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  can_mode_seq #(.IDLE_CYCLES(4)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .bus_idle(bus_idle), .bus_off(bus_off), .ctl_q(ctl_q),
    .rst_status(rst_status), .halt_status(halt_status),
    .sleep_status(sleep_status), .clr_pulse(clr_pulse),
    .cfg_fifo_mode(cfg_fifo_mode), .cfg_id_fmt(cfg_id_fmt),
    .cfg_overrun(cfg_overrun), .cfg_boff_mode(cfg_boff_mode)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_boff();
    bus_off = 1'b1;
    @(negedge clk);
    bus_off = 1'b0;
  endtask

  function automatic logic [15:0] st();
    return {12'd0, sleep_status, clr_pulse, halt_status, rst_status};
  endfunction

  task automatic t_reset();
    chk("R1 ctl", ctl_q, 16'h0500);
    chk("R1 status", st(), 16'h0009);
  endtask

  task automatic t_sleep_ignore();
    do_write(16'h0400);
    tick(6);
    chk("R5 asleep write ignored", ctl_q, 16'h0500);
    chk("R5 asleep still reset", st(), 16'h0009);
    do_write(16'h0000);
    chk("R5 wake mode ignored", ctl_q, 16'h0100);
    chk("R5 awake", {15'd0, sleep_status}, 16'h0000);
  endtask

  task automatic t_cfg_in_reset();
    do_write(16'h090D);
    chk("R7 cfg accepted", ctl_q, 16'h090D);
    chk("R7 cfg outputs", {10'd0, cfg_boff_mode, cfg_overrun, cfg_id_fmt, cfg_fifo_mode},
        16'h001D);
  endtask

  task automatic t_timed_oper();
    do_write(16'h080D);
    tick(3);
    chk("R4 not yet operation", st(), 16'h0001);
    tick(1);
    chk("R2 R4 operation reached", st(), 16'h0000);
    chk("R2 readback", ctl_q, 16'h080D);
  endtask

  task automatic t_cfg_locked();
    do_write(16'h0000);
    tick(5);
    chk("R7 cfg held outside reset", ctl_q, 16'h080D);
    chk("R7 fifo output held", {15'd0, cfg_fifo_mode}, 16'h0001);
  endtask

  task automatic t_sleep_in_oper();
    do_write(16'h0C0D);
    chk("R6 no sleep in operation", {15'd0, sleep_status}, 16'h0000);
    chk("R6 still operation", st(), 16'h0000);
  endtask

  task automatic t_autohalt();
    pulse_boff();
    chk("R8 halted on bus-off", st(), 16'h0002);
    chk("R8 mode field halt", ctl_q, 16'h0A0D);
  endtask

  task automatic t_idle_break();
    bus_idle = 1'b0;
    do_write(16'h080D);
    tick(8);
    chk("R4 busy bus holds halt", st(), 16'h0002);
    bus_idle = 1'b1;
    tick(3);
    bus_idle = 1'b0;
    tick(1);
    bus_idle = 1'b1;
    tick(3);
    chk("R4 count restarted", st(), 16'h0002);
    tick(1);
    chk("R4 operation after restart", st(), 16'h0000);
  endtask

  task automatic t_force();
    bus_idle = 1'b0;
    do_write(16'h0B0D);
    chk("R3 R9 forced reset with clear", st(), 16'h0005);
    chk("R3 readback", ctl_q, 16'h0B0D);
    tick(1);
    chk("R9 clear single cycle", st(), 16'h0001);
  endtask

  task automatic t_no_autohalt();
    do_write(16'h000D);
    tick(5);
    chk("R4 busy bus holds reset", st(), 16'h0001);
    bus_idle = 1'b1;
    tick(4);
    chk("R2 operation again", st(), 16'h0000);
    pulse_boff();
    tick(2);
    chk("R8 no halt without auto mode", st(), 16'h0000);
    chk("R8 mode field unchanged", ctl_q, 16'h000D);
  endtask

  task automatic t_suspend();
    do_write(16'h020D);
    tick(4);
    chk("R2 halt reached", st(), 16'h0002);
    do_write(16'h000D);
    do_write(16'h040D);
    chk("R6 sleep in halt", {15'd0, sleep_status}, 16'h0001);
    tick(8);
    chk("R6 pending frozen asleep", st(), 16'h000A);
    do_write(16'h000D);
    tick(3);
    chk("R6 awake still halt", st(), 16'h0002);
    tick(1);
    chk("R6 pending completes awake", st(), 16'h0000);
  endtask

  task automatic t_timed_reset();
    do_write(16'h010D);
    tick(3);
    chk("R4 reset pending", st(), 16'h0000);
    tick(1);
    chk("R9 reset entry clear", st(), 16'h0005);
    tick(1);
    chk("R9 clear drops", st(), 16'h0001);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual %0d expected below 20000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_sleep_ignore();
    t_cfg_in_reset();
    t_timed_oper();
    t_cfg_locked();
    t_sleep_in_oper();
    t_autohalt();
    t_idle_break();
    t_force();
    t_no_autohalt();
    t_suspend();
    t_timed_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule